// File: doc/BRIEF.md
# Rotating-Priority Interrupt Bus Arbiter

This block decides which of several local interrupt agents receives a delivery. Every agent owns a 4-bit arbitration ID. When a request arrives with a participation mask, the masked agent holding the largest ID wins. The winner's ID then falls to zero and every other agent moves one step up, so the favoured position moves around the agents instead of being tied to their index. A second mode picks the masked agent whose externally computed priority value is the smallest, and leaves the IDs alone.

For a delivery to several destinations, the block arbitrates once per destination and grants one agent per cycle, which gives the order in which the destinations take the interrupt. A single-destination delivery produces exactly one grant. A resynchronize input reloads every ID with its own agent index, whatever the mask. This is also the reset state.

Top module: `rot_prio_arbiter`

## Requirements
- R1: In rotating mode the masked agent with the largest arbitration ID wins, and equal IDs go to the lowest agent index. The grant (grant_valid_o high, grant_idx_o = winner) is visible in the cycle after the edge that samples the request.
- R2: After a rotating-mode win, the winner's arbitration ID is 0.
- R3: After a rotating-mode win, every other agent's ID, masked or not, is one larger than before, unless R4 applies.
- R4: A non-winning agent whose ID was 15 takes the winner's pre-win ID plus one, modulo 16.
- R5: With lowpri_i set at the request, the masked agent with the smallest lp_prio_i field wins, and equal values go to the lowest index. This is a single grant and no ID changes. The field for agent i is lp_prio_i[8i+7:8i].
- R6: resync_i loads every agent's ID with its agent index at the next edge. It takes precedence over a request in the same cycle, which is dropped, and it cancels any destinations still pending.
- R7: A rotating-mode request with multi_i set grants each masked agent exactly once, one per cycle on consecutive cycles, in arbitration order, rotating after each grant. busy_o is high while destinations remain, and requests are ignored while busy_o is high.
- R8: A request with multi_i clear produces exactly one grant, and busy_o stays low.
- R9: A request with an empty mask raises no_winner_o for one cycle, produces no grant and leaves the IDs unchanged.
- R10: After reset, agent i's ID equals i, grant_valid_o, no_winner_o and busy_o are low. arb_ids_o holds agent i's ID in bits [4i+3:4i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request pulse, sampled on the rising edge |
| mask_i | input | N_AGENTS | Participating agents |
| multi_i | input | 1 | Deliver to every masked agent in sequence |
| lowpri_i | input | 1 | Select the smallest-priority mode |
| lp_prio_i | input | N_AGENTS*PRIO_W | Per-agent priority values for the smallest-priority mode |
| resync_i | input | 1 | Reload all IDs with their agent indices |
| grant_valid_o | output | 1 | A winner is presented this cycle |
| grant_idx_o | output | IDX_W | Index of the winner |
| no_winner_o | output | 1 | The last request had an empty mask |
| busy_o | output | 1 | Sequenced destinations remain |
| arb_ids_o | output | N_AGENTS*4 | Current arbitration IDs |

## Verification
Grants, the empty-mask flag and the ID updates come from registers loaded on the edge that samples the request, so they are due one cycle later. A sequenced delivery adds one further grant per following cycle. The bench drives inputs on the falling edge and updates a behavioural model on the rising edge. It then compares every output against that model on the next falling edge, which is exactly one register stage after the stimulus was sampled.

// File: rtl/rpa_pkg.sv
package rpa_pkg;
  localparam int unsigned ARB_ID_W = 4;
  typedef logic [ARB_ID_W-1:0] arb_id_t;
endpackage

// File: rtl/rpa_pick.sv
module rpa_pick #(
  parameter int unsigned N_AGENTS = 4,
  parameter int unsigned KEY_W    = 4,
  parameter bit          FIND_MIN = 1'b0,
  localparam int unsigned IDX_W   = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic [N_AGENTS-1:0]       cand_i,
  input  logic [N_AGENTS*KEY_W-1:0] keys_i,
  output logic                      found_o,
  output logic [IDX_W-1:0]          idx_o
);
  logic [KEY_W-1:0] best;
  logic [KEY_W-1:0] key;
  logic             better;

  // Strict comparison keeps the lowest index on equal keys.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '0;
    key     = '0;
    better  = 1'b0;
    for (int i = 0; i < N_AGENTS; i++) begin
      key    = keys_i[i*KEY_W +: KEY_W];
      better = FIND_MIN ? (key < best) : (key > best);
      if (cand_i[i] && (!found_o || better)) begin
        found_o = 1'b1;
        best    = key;
        idx_o   = i[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/rpa_id_bank.sv
module rpa_id_bank
  import rpa_pkg::*;
#(
  parameter int unsigned N_AGENTS = 4,
  localparam int unsigned IDX_W   = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         resync_i,
  input  logic                         rotate_i,
  input  logic [IDX_W-1:0]             win_idx_i,
  output logic [N_AGENTS*ARB_ID_W-1:0] ids_o
);
  localparam arb_id_t ID_MAX = '1;

  arb_id_t win_pre;
  arb_id_t win_inc;
  logic    id_en;

  assign win_pre = ids_o[win_idx_i*ARB_ID_W +: ARB_ID_W];
  assign win_inc = win_pre + arb_id_t'(1);
  assign id_en   = resync_i | rotate_i;

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
    localparam arb_id_t HOME = arb_id_t'(g);
    arb_id_t id_q;
    arb_id_t id_d;

    always_comb begin
      id_d = id_q;
      if (resync_i) begin
        id_d = HOME;
      end else if (rotate_i) begin
        if (win_idx_i == IDX_W'(g)) begin
          id_d = '0;
        end else if (id_q == ID_MAX) begin
          id_d = win_inc;
        end else begin
          id_d = id_q + arb_id_t'(1);
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        id_q <= HOME;
      end else if (id_en) begin
        id_q <= id_d;
      end
    end

    assign ids_o[g*ARB_ID_W +: ARB_ID_W] = id_q;
  end
endmodule

// File: rtl/rot_prio_arbiter.sv
module rot_prio_arbiter
  import rpa_pkg::*;
#(
  parameter int unsigned N_AGENTS = 4,
  parameter int unsigned PRIO_W   = 8,
  localparam int unsigned IDX_W   = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_i,
  input  logic [N_AGENTS-1:0]          mask_i,
  input  logic                         multi_i,
  input  logic                         lowpri_i,
  input  logic [N_AGENTS*PRIO_W-1:0]   lp_prio_i,
  input  logic                         resync_i,
  output logic                         grant_valid_o,
  output logic [IDX_W-1:0]             grant_idx_o,
  output logic                         no_winner_o,
  output logic                         busy_o,
  output logic [N_AGENTS*ARB_ID_W-1:0] arb_ids_o
);
  logic [N_AGENTS-1:0] pending_q, pending_d;
  logic                gv_q, gv_d;
  logic [IDX_W-1:0]    gi_q, gi_d;
  logic                nw_q, nw_d;

  logic                start_w, step_w, use_low_w, rotate_w;
  logic [N_AGENTS-1:0] cand_w, win_oh_w;
  logic                rot_found, low_found, win_found;
  logic [IDX_W-1:0]    rot_idx, low_idx, win_idx;

  assign busy_o    = |pending_q;
  assign start_w   = req_i & ~busy_o & ~resync_i;
  assign step_w    = (busy_o | start_w) & ~resync_i;
  assign cand_w    = busy_o ? pending_q : mask_i;
  assign use_low_w = start_w & lowpri_i;

  rpa_pick #(.N_AGENTS(N_AGENTS), .KEY_W(ARB_ID_W), .FIND_MIN(1'b0)) u_pick_rot (
    .cand_i  (cand_w),
    .keys_i  (arb_ids_o),
    .found_o (rot_found),
    .idx_o   (rot_idx)
  );

  rpa_pick #(.N_AGENTS(N_AGENTS), .KEY_W(PRIO_W), .FIND_MIN(1'b1)) u_pick_low (
    .cand_i  (cand_w),
    .keys_i  (lp_prio_i),
    .found_o (low_found),
    .idx_o   (low_idx)
  );

  assign win_found = use_low_w ? low_found : rot_found;
  assign win_idx   = use_low_w ? low_idx   : rot_idx;
  assign win_oh_w  = N_AGENTS'(1) << win_idx;
  assign rotate_w  = step_w & win_found & ~use_low_w;

  rpa_id_bank #(.N_AGENTS(N_AGENTS)) u_ids (
    .clk       (clk),
    .rst_n     (rst_n),
    .resync_i  (resync_i),
    .rotate_i  (rotate_w),
    .win_idx_i (win_idx),
    .ids_o     (arb_ids_o)
  );

  always_comb begin
    gv_d      = step_w & win_found;
    gi_d      = gv_d ? win_idx : gi_q;
    nw_d      = start_w & ~win_found;
    pending_d = pending_q;
    if (resync_i) begin
      pending_d = '0;
    end else if (busy_o) begin
      pending_d = pending_q & ~win_oh_w;
    end else if (start_w && multi_i && !lowpri_i) begin
      pending_d = mask_i & ~win_oh_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= '0;
      gv_q      <= 1'b0;
      gi_q      <= '0;
      nw_q      <= 1'b0;
    end else begin
      pending_q <= pending_d;
      gv_q      <= gv_d;
      gi_q      <= gi_d;
      nw_q      <= nw_d;
    end
  end

  assign grant_valid_o = gv_q;
  assign grant_idx_o   = gi_q;
  assign no_winner_o   = nw_q;
endmodule

// File: rtl/rpa_checker.sv
module rpa_checker #(
  parameter int unsigned N_AGENTS = 4,
  parameter int unsigned IDX_W    = 2,
  parameter int unsigned ID_W     = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_i,
  input logic                     resync_i,
  input logic                     lowpri_i,
  input logic [N_AGENTS-1:0]      mask_i,
  input logic                     busy_o,
  input logic                     grant_valid_o,
  input logic [IDX_W-1:0]         grant_idx_o,
  input logic                     no_winner_o,
  input logic [N_AGENTS*ID_W-1:0] arb_ids_o,
  input logic                     rotate_w
);
  function automatic logic [N_AGENTS*ID_W-1:0] home_pattern();
    logic [N_AGENTS*ID_W-1:0] p;
    p = '0;
    for (int i = 0; i < N_AGENTS; i++) p[i*ID_W +: ID_W] = ID_W'(i);
    return p;
  endfunction

  localparam logic [N_AGENTS*ID_W-1:0] HOME = home_pattern();

  a_r2_winner_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rotate_w) |-> arb_ids_o[grant_idx_o*ID_W +: ID_W] == '0);

  a_r6_resync_loads_home: assert property (@(posedge clk) disable iff (!rst_n)
    $past(resync_i) |-> arb_ids_o == HOME);

  a_r5_lowpri_keeps_ids: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !busy_o && !resync_i && lowpri_i) |=> $stable(arb_ids_o));

  a_r9_empty_mask_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !busy_o && !resync_i && mask_i == '0) |=> (no_winner_o && !grant_valid_o && $stable(arb_ids_o)));

  a_r7_busy_no_empty_flag: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !no_winner_o);
endmodule

bind rot_prio_arbiter rpa_checker #(
  .N_AGENTS (N_AGENTS),
  .IDX_W    (IDX_W),
  .ID_W     (rpa_pkg::ARB_ID_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_i         (req_i),
  .resync_i      (resync_i),
  .lowpri_i      (lowpri_i),
  .mask_i        (mask_i),
  .busy_o        (busy_o),
  .grant_valid_o (grant_valid_o),
  .grant_idx_o   (grant_idx_o),
  .no_winner_o   (no_winner_o),
  .arb_ids_o     (arb_ids_o),
  .rotate_w      (rotate_w)
);

// File: tb/rot_prio_arbiter_tb.sv
`timescale 1ns/1ps
module rot_prio_arbiter_tb;
  localparam int N  = 4;
  localparam int PW = 8;
  localparam int IW = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            req_i, multi_i, lowpri_i, resync_i;
  logic [N-1:0]    mask_i;
  logic [N*PW-1:0] lp_prio_i;
  logic            grant_valid_o, no_winner_o, busy_o;
  logic [IW-1:0]   grant_idx_o;
  logic [N*4-1:0]  arb_ids_o;

  always #10 clk = ~clk;

  rot_prio_arbiter #(.N_AGENTS(N), .PRIO_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_i(mask_i),
    .multi_i(multi_i), .lowpri_i(lowpri_i), .lp_prio_i(lp_prio_i),
    .resync_i(resync_i), .grant_valid_o(grant_valid_o),
    .grant_idx_o(grant_idx_o), .no_winner_o(no_winner_o),
    .busy_o(busy_o), .arb_ids_o(arb_ids_o)
  );

  int checks = 0;
  int fails  = 0;
  bit compare_on = 0;

  // behavioural model
  int m_id[N];
  bit m_pend[N];
  bit e_gv, e_nw;
  int e_gi;

  function automatic bit any_pend();
    for (int j = 0; j < N; j++) if (m_pend[j]) return 1;
    return 0;
  endfunction

  function automatic int pick_max(bit c[N]);
    int w = -1;
    for (int j = 0; j < N; j++) if (c[j] && (w < 0 || m_id[j] > m_id[w])) w = j;
    return w;
  endfunction

  task automatic rotate(int w);
    int pre = m_id[w];
    for (int j = 0; j < N; j++) begin
      if (j == w) m_id[j] = 0;
      else if (m_id[j] == 15) m_id[j] = (pre + 1) % 16;
      else m_id[j] = m_id[j] + 1;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < N; j++) begin m_id[j] = j; m_pend[j] = 0; end
      e_gv = 0; e_nw = 0; e_gi = 0;
    end else begin
      bit c[N];
      int w;
      e_gv = 0; e_nw = 0;
      if (resync_i) begin
        for (int j = 0; j < N; j++) begin m_id[j] = j; m_pend[j] = 0; end
      end else if (any_pend()) begin
        w = pick_max(m_pend);
        rotate(w);
        m_pend[w] = 0;
        e_gv = 1; e_gi = w;
      end else if (req_i) begin
        for (int j = 0; j < N; j++) c[j] = mask_i[j];
        w = -1;
        if (lowpri_i) begin
          for (int j = 0; j < N; j++)
            if (c[j] && (w < 0 || lp_prio_i[j*PW +: PW] < lp_prio_i[w*PW +: PW])) w = j;
        end else begin
          w = pick_max(c);
        end
        if (w < 0) e_nw = 1;
        else begin
          e_gv = 1; e_gi = w;
          if (!lowpri_i) begin
            rotate(w);
            if (multi_i) for (int j = 0; j < N; j++) m_pend[j] = c[j] && (j != w);
          end
        end
      end
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && compare_on) begin
      check(grant_valid_o == e_gv, "R1/R5/R7/R8 grant_valid", grant_valid_o, e_gv);
      if (e_gv) check(int'(grant_idx_o) == e_gi, "R1/R5/R7/R8 grant_idx", grant_idx_o, e_gi);
      check(no_winner_o == e_nw, "R9 no_winner", no_winner_o, e_nw);
      check(busy_o == any_pend(), "R7 busy", busy_o, any_pend());
      for (int j = 0; j < N; j++)
        check(int'(arb_ids_o[j*4 +: 4]) == m_id[j], "R2/R3/R4/R6 arb_id", arb_ids_o[j*4 +: 4], m_id[j]);
    end
  end

  task automatic drive(bit rq, logic [N-1:0] m, bit mu, bit lp, bit rs);
    @(negedge clk);
    req_i = rq; mask_i = m; multi_i = mu; lowpri_i = lp; resync_i = rs;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) drive(0, '0, 0, 0, 0);
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; req_i = 0; mask_i = '0; multi_i = 0; lowpri_i = 0; resync_i = 0;
    lp_prio_i = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(grant_valid_o == 0, "R10 grant_valid", grant_valid_o, 0);
    check(no_winner_o == 0, "R10 no_winner", no_winner_o, 0);
    check(busy_o == 0, "R10 busy", busy_o, 0);
    for (int j = 0; j < N; j++)
      check(int'(arb_ids_o[j*4 +: 4]) == j, "R10 arb_id", arb_ids_o[j*4 +: 4], j);
    rst_n = 1;
    compare_on = 1;
    idle(2);
    // R1 full mask: agent 3 wins from home IDs; R8 single
    drive(1, 4'b1111, 0, 0, 0); idle(2);
    // R4: agent 0 always wins alone, others climb through 15
    for (int k = 0; k < 16; k++) drive(1, 4'b0001, 0, 0, 0);
    idle(2);
    // R9 empty mask, single and multi
    drive(1, 4'b0000, 0, 0, 0); drive(1, 4'b0000, 1, 0, 0); idle(2);
    // R7 multi sequence with request ignored while busy
    drive(1, 4'b1111, 1, 0, 0); drive(1, 4'b0010, 0, 0, 0); idle(5);
    // R5 lowest priority with tie to lowest index
    lp_prio_i = {8'd9, 8'd3, 8'd3, 8'd7};
    drive(1, 4'b1110, 0, 1, 0); idle(1);
    drive(1, 4'b1111, 1, 1, 0); idle(2);
    // R6 resync overrides a request and aborts a sequence
    drive(1, 4'b1111, 0, 0, 1); idle(1);
    drive(1, 4'b1011, 1, 0, 0); drive(0, '0, 0, 0, 1); idle(3);
    // random mix
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      for (int j = 0; j < N; j++) lp_prio_i[j*PW +: PW] = PW'($urandom_range(0, 3));
      req_i    = $urandom_range(0, 1);
      mask_i   = N'($urandom);
      multi_i  = $urandom_range(0, 1);
      lowpri_i = ($urandom_range(0, 3) == 0);
      resync_i = ($urandom_range(0, 31) == 0);
    end
    idle(6);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule